// File: doc/BRIEF.md
# Bit-Serial Binary Dot-Product Unit

This processing element forms the dot product of a group of parallel weights with a group of activations that arrive one bit column per cycle. Each weight is a parallel two's complement word. The activations are fed most significant bit first. In every cycle each lane's activation bit gates its weight into a partial product. A binary adder tree reduces the lanes to one partial sum. An accumulator doubles its running value and adds that sum. The number of columns in a loop is the activation precision, which is picked at run time for each layer. This lets a layer with narrow activations finish in fewer cycles.

A loop begins with a start pulse, which carries the precision, the signedness of the activations and the first column. The following columns arrive on the next cycles. A one-cycle done strobe marks the point where the result port holds the completed dot product. When the activations are signed, the contribution of the most significant column is subtracted instead of added. The lane count must be a power of two.

Top module: `serial_dot_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: `start_i` is accepted only when no loop is running. A start pulse, a different precision or a different signedness presented while a loop is running has no effect on that loop's result or timing.
- R3: The loop length p is `prec_i` sampled at the accepted start, limited to the range 1..PMAX (0 becomes 1, values above PMAX become PMAX). `done_o` is high for exactly one cycle, p cycles after the clock edge that accepted the start.
- R4: The column presented with the accepted start is activation bit p-1 (most significant). The k-th following cycle carries bit p-1-k.
- R5: Lane i takes its activation bit from `col_i[i]` and its weight, as a signed WBITS-bit value, from `wt_i[i*WBITS +: WBITS]`. A lane whose bit is 0 contributes nothing in that cycle.
- R6: With `signed_i` = 0 at start, the result is the sum over lanes of weight times the p-bit unsigned activation.
- R7: With `signed_i` = 1 at start, each activation is the p-bit two's complement value, so its most significant column carries weight -2^(p-1).
- R8: The accumulator is cleared at the start of every loop, so a result never depends on data from an earlier loop.
- R9: `result_o` keeps the completed value from the done cycle until the next accepted start.
- R10: A start presented in the same cycle as `done_o` is accepted, so loops can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a loop; carries the first column |
| prec_i | input | $clog2(PMAX+1) | Activation precision in bits, sampled at start |
| signed_i | input | 1 | Activations are two's complement, sampled at start |
| col_i | input | LANES | Current activation bit column, one bit per lane |
| wt_i | input | LANES*WBITS | Parallel two's complement weights, lane 0 in the low bits |
| result_o | output | WBITS+$clog2(LANES)+PMAX+1 | Signed dot product |
| done_o | output | 1 | One-cycle strobe: result is complete |

## Verification
Two situations are hard to reach from the ports. The first is a start pulse, precision or signedness arriving while a loop is running. The bench injects these on the second column of some loops and checks that the result and the done timing still match the original request. The second is a loop that begins on the very cycle a previous loop reports done. The bench chains loops without idle cycles, launching the next start on the same cycle it samples the done strobe. Every precision from 1 to 16 is swept in both signed and unsigned mode, using extreme and random weights and activations.

// File: rtl/sdu_pkg.sv
`timescale 1ns/1ps
package sdu_pkg;
  // Limit a requested precision to the range 1..pmax.
  function automatic int clamp_prec(input int req, input int pmax);
    if (req < 1) return 1;
    if (req > pmax) return pmax;
    return req;
  endfunction

  // Gate one weight by one activation bit.
  function automatic longint gate_term(input logic bit_in, input longint weight);
    return bit_in ? weight : 64'sd0;
  endfunction
endpackage

// File: rtl/sdu_ppgen.sv
`timescale 1ns/1ps
module sdu_ppgen #(
  parameter int LANES = 4,
  parameter int WBITS = 8,
  parameter int SW    = 10
) (
  input  logic [LANES-1:0]       col,
  input  logic [LANES*WBITS-1:0] wt,
  output logic [LANES*SW-1:0]    terms
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [SW-1:0] wext;
    assign wext = SW'($signed(wt[i*WBITS +: WBITS]));
    assign terms[i*SW +: SW] = col[i] ? wext : '0;
  end
endmodule

// File: rtl/sdu_addtree.sv
`timescale 1ns/1ps
module sdu_addtree #(
  parameter int LANES = 4,
  parameter int SW    = 10
) (
  input  logic [LANES*SW-1:0]  terms,
  output logic signed [SW-1:0] sum
);
  localparam int LVL = $clog2(LANES);

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int N = LANES >> l;
    logic [N-1:0][SW-1:0] row;
    if (l == 0) begin : g_leaf
      assign row = terms;
    end else begin : g_node
      for (genvar n = 0; n < N; n++) begin : g_add
        assign row[n] = SW'($signed(g_lvl[l-1].row[2*n]) + $signed(g_lvl[l-1].row[2*n+1]));
      end
    end
  end

  assign sum = $signed(g_lvl[LVL].row[0]);
endmodule

// File: rtl/sdu_ctrl.sv
`timescale 1ns/1ps
module sdu_ctrl #(
  parameter int PMAX = 16,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] prec_i,
  output logic          take_o,
  output logic          first_o,
  output logic          done_o
);
  import sdu_pkg::*;

  logic          busy_q;
  logic [PW-1:0] rem_q;
  logic [PW-1:0] peff;
  logic          last;

  assign peff    = PW'(clamp_prec(int'(prec_i), PMAX));
  assign first_o = start_i && !busy_q;
  assign take_o  = first_o || busy_q;
  assign last    = first_o ? (peff == PW'(1)) : (rem_q == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= take_o && last;
      if (first_o) begin
        busy_q <= !last;
        rem_q  <= peff - PW'(1);
      end else if (busy_q) begin
        busy_q <= !last;
        rem_q  <= rem_q - PW'(1);
      end
    end
  end
endmodule

// File: rtl/sdu_accum.sv
`timescale 1ns/1ps
module sdu_accum #(
  parameter int SW   = 10,
  parameter int ACCW = 27
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   first,
  input  logic                   neg,
  input  logic signed [SW-1:0]   sum,
  output logic signed [ACCW-1:0] acc
);
  logic signed [ACCW-1:0] ext;
  assign ext = ACCW'(sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (take) begin
      if (first) acc <= neg ? -ext : ext;
      else       acc <= (acc <<< 1) + ext;
    end
  end
endmodule

// File: rtl/serial_dot_unit.sv
`timescale 1ns/1ps
module serial_dot_unit #(
  parameter int LANES = 4,
  parameter int WBITS = 8,
  parameter int PMAX  = 16,
  localparam int PW   = $clog2(PMAX + 1),
  localparam int SW   = WBITS + $clog2(LANES),
  localparam int ACCW = SW + PMAX + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [PW-1:0]          prec_i,
  input  logic                   signed_i,
  input  logic [LANES-1:0]       col_i,
  input  logic [LANES*WBITS-1:0] wt_i,
  output logic [ACCW-1:0]        result_o,
  output logic                   done_o
);
  logic                   take_w;
  logic                   first_w;
  logic [LANES*SW-1:0]    terms_w;
  logic signed [SW-1:0]   tree_sum_w;
  logic signed [ACCW-1:0] acc_w;

  sdu_ctrl #(.PMAX(PMAX), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i),
    .take_o(take_w), .first_o(first_w), .done_o(done_o)
  );

  sdu_ppgen #(.LANES(LANES), .WBITS(WBITS), .SW(SW)) u_pp (
    .col(col_i), .wt(wt_i), .terms(terms_w)
  );

  sdu_addtree #(.LANES(LANES), .SW(SW)) u_tree (
    .terms(terms_w), .sum(tree_sum_w)
  );

  sdu_accum #(.SW(SW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take_w), .first(first_w),
    .neg(signed_i), .sum(tree_sum_w), .acc(acc_w)
  );

  assign result_o = acc_w;
endmodule

// File: rtl/sdu_chk.sv
`timescale 1ns/1ps
module sdu_chk #(
  parameter int PMAX = 16,
  parameter int PW   = 5,
  parameter int SW   = 10,
  parameter int ACCW = 27
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        prec_i,
  input logic                 signed_i,
  input logic                 take_w,
  input logic                 first_w,
  input logic signed [SW-1:0] tree_sum_w,
  input logic [ACCW-1:0]      result_o,
  input logic                 done_o
);
  import sdu_pkg::*;

  logic [PW:0] cyc_q;
  logic [PW:0] plen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      plen_q <= '0;
    end else if (first_w) begin
      cyc_q  <= (PW+1)'(1);
      plen_q <= (PW+1)'(clamp_prec(int'(prec_i), PMAX));
    end else if (take_w) begin
      cyc_q <= cyc_q + (PW+1)'(1);
    end
  end

  // R3
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == plen_q));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> $stable(result_o));

  // R8
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_w && !signed_i) |=> (result_o == ACCW'($past(tree_sum_w))));

  // R7
  first_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_w && signed_i) |=> (result_o == ACCW'(-ACCW'($past(tree_sum_w)))));

  // R4
  shift_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !first_w) |=>
      (result_o == ACCW'(($past(result_o) << 1) + ACCW'($past(tree_sum_w)))));
endmodule

bind serial_dot_unit sdu_chk #(.PMAX(PMAX), .PW(PW), .SW(SW), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prec_i(prec_i), .signed_i(signed_i),
  .take_w(take_w), .first_w(first_w), .tree_sum_w(tree_sum_w),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/serial_dot_unit_test.sv
`timescale 1ns/1ps
module serial_dot_unit_test;
  localparam int LANES = 4;
  localparam int WBITS = 8;
  localparam int PMAX  = 16;
  localparam int PW    = $clog2(PMAX + 1);
  localparam int ACCW  = WBITS + $clog2(LANES) + PMAX + 1;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start_i = 1'b0;
  logic [PW-1:0]          prec_i = '0;
  logic                   signed_i = 1'b0;
  logic [LANES-1:0]       col_i = '0;
  logic [LANES*WBITS-1:0] wt_i = '0;
  logic [ACCW-1:0]        result_o;
  logic                   done_o;

  int checks = 0;
  int fails  = 0;
  logic signed [WBITS-1:0] wv [LANES];
  logic [PMAX-1:0]         av [LANES];

  always #2.5 clk = ~clk;

  serial_dot_unit #(.LANES(LANES), .WBITS(WBITS), .PMAX(PMAX)) uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint res_val();
    logic signed [ACCW-1:0] r;
    r = result_o;
    return longint'(r);
  endfunction

  // Runs one loop starting at a falling edge; returns at the falling edge where done is seen.
  task automatic run_op(input int preq, input bit sgn, input bit poke, input string tag);
    int     p;
    longint exp;
    bit     early;
    p = (preq < 1) ? 1 : ((preq > PMAX) ? PMAX : preq);
    exp = 0;
    early = 0;
    for (int i = 0; i < LANES; i++) begin
      longint a;
      a = longint'(av[i]) & ((64'sd1 <<< p) - 1);
      if (sgn && a[p-1]) a = a - (64'sd1 <<< p);
      exp += longint'(wv[i]) * a;
      wt_i[i*WBITS +: WBITS] = wv[i];
    end
    for (int k = 0; k < p; k++) begin
      if (k > 0 && done_o) early = 1;
      start_i  = (k == 0) || (poke && k == 1);
      prec_i   = (k == 0) ? PW'(preq) : PW'($urandom_range(1, PMAX));
      signed_i = (k == 0) ? sgn : !sgn;
      for (int i = 0; i < LANES; i++) col_i[i] = av[i][p-1-k];
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
    // R3: done exactly p cycles after the accepted start
    check(done_o && !early, "R3", longint'({early, done_o}), 1);
    check(res_val() == exp, tag, res_val(), exp);
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < LANES; i++) begin
      case (mode)
        0: begin av[i] = '1; wv[i] = (i % 2) ? 8'sh7f : -8'sd128; end
        1: begin av[i] = 16'haaaa ^ PMAX'(i); wv[i] = WBITS'(8'sd37 - 8'(i * 29)); end
        default: begin av[i] = PMAX'($urandom); wv[i] = WBITS'($urandom); end
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done_o == 1'b0, "R1", longint'(done_o), 0);
    check(res_val() == 0, "R1", res_val(), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R7 sweep over every precision, both modes, several patterns
    for (int p = 1; p <= PMAX; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 4; m++) begin
          fill(m);
          run_op(p, bit'(s), 1'b0, s ? "R7" : "R6");
        end
      end
    end

    // R3: out-of-range precision requests clamp
    fill(2); run_op(0, 1'b0, 1'b0, "R3");
    fill(2); run_op(17, 1'b1, 1'b0, "R3");
    fill(0); run_op(31, 1'b0, 1'b0, "R3");

    // R4: only the most significant column set, versus only the least
    for (int p = 2; p <= PMAX; p += 7) begin
      for (int i = 0; i < LANES; i++) begin av[i] = PMAX'(1) << (p - 1); wv[i] = 8'sd3; end
      run_op(p, 1'b0, 1'b0, "R4");
      for (int i = 0; i < LANES; i++) av[i] = PMAX'(1);
      run_op(p, 1'b0, 1'b0, "R4");
    end

    // R5: one lane active at a time
    for (int l = 0; l < LANES; l++) begin
      for (int i = 0; i < LANES; i++) begin av[i] = (i == l) ? 16'h00b5 : 16'h0; wv[i] = WBITS'(8'sd11 * 8'(i + 1)); end
      run_op(8, 1'b0, 1'b0, "R5");
    end

    // R2: start, precision and signedness changes during a running loop
    for (int p = 2; p <= PMAX; p += 3) begin
      fill(2); run_op(p, 1'b0, 1'b1, "R2");
      fill(2); run_op(p, 1'b1, 1'b1, "R2");
    end

    // R10 / R8: back-to-back loops, each result independent of the previous one
    fill(0); run_op(16, 1'b0, 1'b0, "R10");
    fill(1); run_op(5, 1'b1, 1'b0, "R8");
    fill(2); run_op(1, 1'b0, 1'b0, "R10");
    for (int i = 0; i < LANES; i++) av[i] = '0;
    run_op(9, 1'b1, 1'b0, "R8");

    // R9: result holds while idle
    fill(0); run_op(12, 1'b1, 1'b0, "R9");
    begin
      longint held;
      held = res_val();
      for (int c = 0; c < 3; c++) begin
        col_i = LANES'($urandom);
        wt_i  = (LANES*WBITS)'($urandom);
        @(negedge clk);
        check(res_val() == held, "R9", res_val(), held);
        check(done_o == 1'b0, "R9", longint'(done_o), 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule